// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Execution Unit

This block carries out the second opcode byte of the prefixed bit-manipulation instructions of an 8-bit processor core on a single 8-bit operand. The byte splits into a two-bit group, a three-bit field and a three-bit operand selector. The field is a shift kind in the shift group and a bit number in the three bit groups. The unit is purely combinational. In the same evaluation it returns the new operand value, a write-back enable, the final flag nibble, a mask of the flags it left untouched, and the number of machine cycles the instruction takes.

The surrounding core fetches the operand from the register file, or from memory when the selector is 110, and stores the result when the write enable is high. Flags use the nibble {Z, N, H, C}, with Z in bit 3 and C in bit 0. `flags_out` already merges the preserved flags from `flags_in`, so the core can load it directly. `flag_keep` tells a core that tracks flag updates separately which bits were preserved.

Top module: `prefix_bitops_unit`

## Requirements
- R1: `sel_reg` equals opcode bits 2..0, and `sel_mem` is high exactly when those bits are 110 (codes 000..111 other than 110 are B, C, D, E, H, L, -, A).
- R2: Group 00 with field 000 rotates left, copying bit 7 into bit 0 and into C. Field 001 rotates right, copying bit 0 into bit 7 and into C.
- R3: Field 010 rotates left through carry, so the old C enters bit 0 and bit 7 goes to C. Field 011 rotates right through carry, so the old C enters bit 7 and bit 0 goes to C.
- R4: Field 100 shifts left and fills bit 0 with zero. Field 101 shifts right and keeps bit 7. Field 111 shifts right and fills bit 7 with zero. All three move the bit shifted out into C.
- R5: Field 110 exchanges the two nibbles and clears C.
- R6: In group 00, Z is 1 exactly when the result is zero, N and H are 0, and `flag_keep` is 0000.
- R7: Group 01 tests the bit numbered by opcode bits 5..3. Z is the inverse of that bit, N is 0, H is 1, C is kept, `flag_keep` is 0001, the write enable is low, and the result equals the operand.
- R8: Group 10 clears and group 11 sets the numbered bit and leaves the other seven bits alone. All flags equal `flags_in`, and `flag_keep` is 1111.
- R9: `wr_en` is high for every group except 01.
- R10: `cycles` is 2 for a register operand. For the memory operand it is 3 in group 01 and 4 in every other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_byte | input | 8 | Second byte of the prefixed instruction |
| operand | input | 8 | Operand value fetched by the core |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 8 | Value to write back |
| wr_en | output | 1 | Result must be written back |
| flags_out | output | 4 | Final flags {Z,N,H,C} |
| flag_keep | output | 4 | 1 marks a flag left unchanged |
| cycles | output | 3 | Machine cycles for the instruction |
| sel_reg | output | 3 | Operand selector field |
| sel_mem | output | 1 | Operand is the memory location |

## Verification
The cases that are hardest to reach are the ones where the incoming carry decides the result bit: rotates through carry, and the flag that the bit test keeps. Random operands seldom hit them with both carry values. For that reason, every one of the 256 opcode bytes is applied with random operands under both C values. Directed operands are added where a single bit decides the outcome: 00, 01, 80 and 7F for sign retention, zero results and testing the top bit.

// File: rtl/prefix_bitops_unit.sv
module prefix_bitops_unit #(
  parameter int          DW          = 8,
  parameter logic [2:0]  MEM_SEL     = 3'b110,
  parameter int          CYC_REG     = 2,
  parameter int          CYC_MEM_TST = 3,
  parameter int          CYC_MEM_RMW = 4,
  parameter int          CW          = 3
) (
  input  logic [7:0]    op_byte,
  input  logic [DW-1:0] operand,
  input  logic [3:0]    flags_in,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic [3:0]    flags_out,
  output logic [3:0]    flag_keep,
  output logic [CW-1:0] cycles,
  output logic [2:0]    sel_reg,
  output logic          sel_mem
);
  localparam int HALF = DW / 2;

  logic [1:0]    grp;
  logic [2:0]    fld;
  logic [DW-1:0] bmask;
  logic [DW-1:0] res_c;
  logic          cout;
  logic [3:0]    fl_c;
  logic [3:0]    keep_c;

  assign grp     = op_byte[7:6];
  assign fld     = op_byte[5:3];
  assign sel_reg = op_byte[2:0];
  assign sel_mem = (sel_reg == MEM_SEL);
  assign bmask   = DW'(1) << fld;

  always_comb begin
    res_c  = operand;
    cout   = flags_in[0];
    fl_c   = flags_in;
    keep_c = 4'b1111;
    case (grp)
      2'b00: begin
        case (fld)
          3'd0: begin res_c = {operand[DW-2:0], operand[DW-1]}; cout = operand[DW-1]; end
          3'd1: begin res_c = {operand[0], operand[DW-1:1]};    cout = operand[0];    end
          3'd2: begin res_c = {operand[DW-2:0], flags_in[0]};   cout = operand[DW-1]; end
          3'd3: begin res_c = {flags_in[0], operand[DW-1:1]};   cout = operand[0];    end
          3'd4: begin res_c = {operand[DW-2:0], 1'b0};          cout = operand[DW-1]; end
          3'd5: begin res_c = {operand[DW-1], operand[DW-1:1]}; cout = operand[0];    end
          3'd6: begin res_c = {operand[HALF-1:0], operand[DW-1:HALF]}; cout = 1'b0;   end
          default: begin res_c = {1'b0, operand[DW-1:1]};      cout = operand[0];    end
        endcase
        fl_c   = {res_c == '0, 1'b0, 1'b0, cout};
        keep_c = 4'b0000;
      end
      2'b01: begin
        fl_c   = {(operand & bmask) == '0, 1'b0, 1'b1, flags_in[0]};
        keep_c = 4'b0001;
      end
      2'b10: res_c = operand & ~bmask;
      default: res_c = operand | bmask;
    endcase

    if (grp == 2'b01) begin
      a_r7_test_no_write: assert (res_c == operand && fl_c[2:1] == 2'b01 && fl_c[0] == flags_in[0])
        else $error("bit test altered operand or flags");
    end
    if (grp[1]) begin
      a_r8_single_bit: assert (((res_c ^ operand) & ~bmask) == '0 && fl_c == flags_in)
        else $error("bit clear/set touched other bits or flags");
    end
    if (grp == 2'b00 && fld == 3'd6) begin
      a_r5_swap_popcount: assert ($countones(res_c) == $countones(operand) && !fl_c[0])
        else $error("nibble swap lost bits or kept carry");
    end
    for (int i = 0; i < 4; i++) begin
      if (keep_c[i]) begin
        a_r6_keep_mask: assert (fl_c[i] == flags_in[i]) else $error("kept flag changed");
      end
    end
  end

  assign result    = res_c;
  assign flags_out = fl_c;
  assign flag_keep = keep_c;
  assign wr_en     = (grp != 2'b01);
  assign cycles    = !sel_mem ? CW'(CYC_REG) :
                     (grp == 2'b01) ? CW'(CYC_MEM_TST) : CW'(CYC_MEM_RMW);

  always_comb begin
    a_r10_cycle_range: assert (cycles >= CW'(CYC_REG) && cycles <= CW'(CYC_MEM_RMW) &&
                               (sel_mem || cycles == CW'(CYC_REG)))
      else $error("cycle count out of range");
    a_r9_write_vs_keep: assert (wr_en || flag_keep == 4'b0001)
      else $error("no write outside bit test");
  end
endmodule

// File: tb/test_prefix_bitops_unit.sv
module test_prefix_bitops_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] op_byte = '0, operand = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] result;
  logic       wr_en;
  logic [3:0] flags_out, flag_keep;
  logic [2:0] cycles, sel_reg;
  logic       sel_mem;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefix_bitops_unit i_prefix_bitops_unit (
    .op_byte(op_byte), .operand(operand), .flags_in(flags_in),
    .result(result), .wr_en(wr_en), .flags_out(flags_out), .flag_keep(flag_keep),
    .cycles(cycles), .sel_reg(sel_reg), .sel_mem(sel_mem));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s op=%h x=%h f=%h act=%h exp=%h", req, op_byte, operand, flags_in, act, exp);
    end
  endtask

  function automatic string res_tag(input logic [7:0] op);
    if (op[7:6] == 2'b01) return "R7";
    if (op[7]) return "R8";
    case (op[5:3])
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd6: return "R5";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [8:0] ref_shift(input logic [2:0] k, input logic [7:0] x, input logic c);
    logic [15:0] dbl;
    dbl = {x, x};
    case (k)
      3'd0: return {x[7], dbl[14:7]};
      3'd1: return {x[0], dbl[8:1]};
      3'd2: return {x[7], x[6:0], c};
      3'd3: return {x[0], c, x[7:1]};
      3'd4: return {x[7], x << 1};
      3'd5: return {x[0], 8'($signed(x) >>> 1)};
      3'd6: return {1'b0, x[3:0], x[7:4]};
      default: return {x[0], x >> 1};
    endcase
  endfunction

  task automatic apply(input logic [7:0] op, input logic [7:0] x, input logic [3:0] f);
    logic [8:0] sh;
    logic [7:0] er;
    logic [3:0] ef, ek;
    logic       tb;
    op_byte = op; operand = x; flags_in = f;
    @(negedge clk);
    tb = x[op[5:3]];
    sh = ref_shift(op[5:3], x, f[0]);
    case (op[7:6])
      2'b00: begin er = sh[7:0]; ef = {sh[7:0] == 8'h00, 2'b00, sh[8]}; ek = 4'b0000; end
      2'b01: begin er = x; ef = {~tb, 2'b01, f[0]}; ek = 4'b0001; end
      2'b10: begin er = x; er[op[5:3]] = 1'b0; ef = f; ek = 4'b1111; end
      default: begin er = x; er[op[5:3]] = 1'b1; ef = f; ek = 4'b1111; end
    endcase
    chk(res_tag(op), int'(result), int'(er));
    chk(op[7:6] == 2'b00 ? "R6" : res_tag(op), int'(flags_out), int'(ef));
    chk(op[7:6] == 2'b00 ? "R6" : res_tag(op), int'(flag_keep), int'(ek));
    chk("R9", int'(wr_en), int'(op[7:6] != 2'b01));
    chk("R10", int'(cycles), op[2:0] != 3'b110 ? 2 : (op[7:6] == 2'b01 ? 3 : 4));
    chk("R1", int'({sel_mem, sel_reg}), int'({op[2:0] == 3'b110, op[2:0]}));
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk);
    // directed corners
    apply(8'h2F, 8'h80, 4'h0); // R4 sra keeps sign: C0, C=0
    apply(8'h3F, 8'h01, 4'h0); // R4 srl to zero: Z=1, C=1
    apply(8'h37, 8'hF0, 4'h1); // R5 swap clears carry
    apply(8'h17, 8'h80, 4'h1); // R3 rl through carry -> 01, C=1
    apply(8'h1F, 8'h00, 4'h1); // R3 rr carry in -> 80
    apply(8'h7F, 8'h7F, 4'h0); // R7 top bit zero -> Z=1
    apply(8'h46, 8'h01, 4'hF); // R7 memory test, 3 cycles
    apply(8'hBE, 8'hFF, 4'hA); // R8 clear bit 7 of memory, 4 cycles
    apply(8'hC0, 8'h00, 4'h5); // R8 set bit 0
    apply(8'h06, 8'h00, 4'hF); // R2 rlc zero: Z=1
    for (int op = 0; op < 256; op++)
      for (int c = 0; c < 2; c++)
        for (int n = 0; n < 3; n++)
          apply(8'(op), 8'($urandom), {3'($urandom), 1'(c)});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule